// File: doc/BRIEF.md
# Programmable CPU Clock Prescaler

This block turns a free-running oscillator clock into a one-cycle clock-enable pulse for a processor core and its peripherals. A startup timer first holds the enable stream off until the oscillator has settled. The settle time depends on which oscillator source is selected: crystals need a long wait, while the on-chip RC oscillator and an external clock need a short one. Once the timer expires, a clock-ready flag rises and the enable stream starts.

The rate of the enable stream is set by two controls that act in series:
- An 8-bit divisor register that software may write at any time. A value of zero bypasses it. A value N from 1 to 255 divides by 2*(N+1). A new value takes effect only at the end of the divide period in progress, so no pulse interval is ever shortened or stretched.
- A compatibility bit that halves the resulting rate. This doubles the length of the machine cycle, for example from 6 to 12 clocks.

Entering power-down, or a power-monitor reset, clears the startup timer and drops the ready flag. The timer counts again once that request is removed.

Top module: `cpu_clk_prescaler`

## Requirements
- R1: After reset, clk_ready is 0, cpu_ce is 0 and the active divisor is 0.
- R2: When src_sel is 0 (internal RC), 4 (external clock) or any value from 5 to 7, clk_ready rises exactly SHORT_CNT clock edges after the startup count begins.
- R3: When src_sel is 1, 2 or 3 (low-, medium- or high-frequency crystal), clk_ready rises exactly LONG_CNT clock edges after the startup count begins.
- R4: cpu_ce is never asserted while clk_ready is 0.
- R5: While pwr_down or pmon_rst is high, clk_ready is 0 and the startup count is held at zero. The count restarts when both inputs are low.
- R6: With divisor 0 and compat_half at 0, cpu_ce is high on every clock once the block is ready.
- R7: With divisor 0 and compat_half at 1, cpu_ce is a one-cycle pulse every 2 clocks.
- R8: With divisor N in 1..255, cpu_ce pulses every 2*(N+1) clocks, or every 4*(N+1) clocks when compat_half is 1.
- R9: A divisor write (div_wr with div_data) leaves the period in progress unchanged. The new ratio applies from the next period on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 3 | Oscillator source code (0 RC, 1-3 crystal, 4 external) |
| compat_half | input | 1 | Halve the enable rate |
| div_wr | input | 1 | Divisor write strobe |
| div_data | input | 8 | Divisor value to write |
| pwr_down | input | 1 | Power-down request; clears the startup timer |
| pmon_rst | input | 1 | Power-monitor reset; clears the startup timer |
| cpu_ce | output | 1 | CPU clock-enable pulse |
| clk_ready | output | 1 | Oscillator settled flag |

## Verification
The bench builds the block with SHORT_CNT=16 and LONG_CNT=64 and keeps the divisor width at 8. The short settle times let many startups, power-down restarts and monitor resets run within the cycle limit, and each ready edge can be counted to the exact clock. Keeping the full divisor width brings the largest ratio of 512 into reach, as well as mid-period rewrites of the divisor.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [2:0] {
    SRC_RC   = 3'd0,
    SRC_XLO  = 3'd1,
    SRC_XMID = 3'd2,
    SRC_XHI  = 3'd3,
    SRC_EXT  = 3'd4
  } osc_src_e;

  function automatic logic is_crystal(input logic [2:0] sel);
    return (sel == SRC_XLO) || (sel == SRC_XMID) || (sel == SRC_XHI);
  endfunction
endpackage

// File: rtl/cps_startup.sv
module cps_startup #(
  parameter int SHORT_CNT = 256,
  parameter int LONG_CNT  = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] src_sel,
  input  logic       clear,
  output logic       ready
);
  import cps_pkg::*;
  localparam int CNT_W = $clog2(LONG_CNT + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CNT - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CNT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rdy_q, rdy_d;
  logic [CNT_W-1:0] last;

  always_comb begin
    last  = is_crystal(src_sel) ? LONG_LAST : SHORT_LAST;
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (clear) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (!rdy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q >= last) rdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready = rdy_q;

  p_clear_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!rdy_q && cnt_q == '0));
  p_ready_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && !clear) |=> rdy_q);
endmodule

// File: rtl/cps_divider.sv
module cps_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr,
  input  logic [DIV_W-1:0] wdata,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0] n_q, n_d, pend_q, pend_d;
  logic             pv_q, pv_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last;
  logic             term;

  always_comb begin
    last   = (n_q == '0) ? '0 : {n_q, 1'b1};
    term   = run && (cnt_q == last);
    n_d    = n_q;
    pend_d = pend_q;
    pv_d   = pv_q;
    cnt_d  = cnt_q;
    if (!run)      cnt_d = '0;
    else if (term) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
    if ((term || !run) && pv_q) begin
      n_d  = pend_q;
      pv_d = 1'b0;
    end
    if (wr) begin
      pend_d = wdata;
      pv_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q    <= '0;
      pend_q <= '0;
      pv_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      n_q    <= n_d;
      pend_q <= pend_d;
      pv_q   <= pv_d;
      cnt_q  <= cnt_d;
    end
  end

  assign tick = term;

  p_ratio_held_midperiod_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !term) |=> $stable(n_q));
  p_count_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= {n_q, 1'b1});
endmodule

// File: rtl/cps_halver.sv
module cps_halver (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic half,
  input  logic tick_in,
  output logic tick_out
);
  logic ph_q, ph_d;

  always_comb begin
    tick_out = tick_in && (!half || ph_q);
    ph_d     = ph_q;
    if (!run || !half) ph_d = 1'b0;
    else if (tick_in)  ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  p_half_alternates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_out && half) |=> (!half || !tick_out));
endmodule

// File: rtl/cpu_clk_prescaler.sv
module cpu_clk_prescaler #(
  parameter int SHORT_CNT = 256,
  parameter int LONG_CNT  = 1024,
  parameter int DIV_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       src_sel,
  input  logic             compat_half,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_data,
  input  logic             pwr_down,
  input  logic             pmon_rst,
  output logic             cpu_ce,
  output logic             clk_ready
);
  logic [1:0] rsync_q;
  logic       rst_i_n;
  logic       ready, tick_a, tick_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  cps_startup #(.SHORT_CNT(SHORT_CNT), .LONG_CNT(LONG_CNT)) u_start (
    .clk(clk), .rst_n(rst_i_n), .src_sel(src_sel),
    .clear(pwr_down || pmon_rst), .ready(ready)
  );

  cps_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_i_n), .run(ready),
    .wr(div_wr), .wdata(div_data), .tick(tick_a)
  );

  cps_halver u_half (
    .clk(clk), .rst_n(rst_i_n), .run(ready),
    .half(compat_half), .tick_in(tick_a), .tick_out(tick_b)
  );

  assign cpu_ce    = ready && tick_b;
  assign clk_ready = ready;

  p_no_ce_before_ready_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(clk_ready) |-> $past(!cpu_ce));
endmodule

// File: tb/sim_cpu_clk_prescaler.sv
module sim_cpu_clk_prescaler;
  localparam int SHORT = 16;
  localparam int LONG  = 64;

  logic clk = 1'b0;
  logic rst_n, compat_half, div_wr, pwr_down, pmon_rst;
  logic [2:0] src_sel;
  logic [7:0] div_data;
  logic cpu_ce, clk_ready;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  cpu_clk_prescaler #(.SHORT_CNT(SHORT), .LONG_CNT(LONG), .DIV_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .compat_half(compat_half),
    .div_wr(div_wr), .div_data(div_data), .pwr_down(pwr_down),
    .pmon_rst(pmon_rst), .cpu_ce(cpu_ce), .clk_ready(clk_ready)
  );

  always @(negedge clk) if (rst_n && !clk_ready && cpu_ce) begin
    fails++; $display("FAIL R4: cpu_ce=1 while clk_ready=0 (expected 0)");
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic interval(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!cpu_ce && n < 4000);
  endtask

  task automatic write_div(input int v);
    @(negedge clk); div_wr = 1'b1; div_data = 8'(v);
    @(negedge clk); div_wr = 1'b0;
  endtask

  task automatic settle_ratio(input int n, input int half, input int exp, input string req);
    int d;
    compat_half = half[0];
    write_div(n);
    interval(d); interval(d); interval(d);
    interval(d); chk(req, d, exp);
    interval(d); chk(req, d, exp);
  endtask

  task automatic startup_from(input logic [2:0] src, input int exp, input string req, input bit use_pm);
    int k;
    src_sel = src;
    @(negedge clk);
    if (use_pm) pmon_rst = 1'b1; else pwr_down = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R5", clk_ready, 0);
    chk("R5", cpu_ce, 0);
    pwr_down = 1'b0; pmon_rst = 1'b0;
    k = 0;
    while (!clk_ready && k < 5000) begin @(negedge clk); k++; end
    chk(req, k, exp);
  endtask

  task automatic t_reset;
    int k;
    rst_n = 1'b0; src_sel = 3'd0; compat_half = 1'b0; div_wr = 1'b0;
    div_data = 8'd0; pwr_down = 1'b0; pmon_rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", clk_ready, 0);
    chk("R1", cpu_ce, 0);
    rst_n = 1'b1;
    k = 0;
    while (!clk_ready && k < 100) begin @(negedge clk); k++; end
    chk("R1", (k >= SHORT && k <= SHORT + 3) ? 1 : 0, 1);
    chk("R1 divisor 0", cpu_ce, 1);
  endtask

  task automatic t_glitchfree;
    int n, d;
    compat_half = 1'b0;
    write_div(3);
    interval(d); interval(d); interval(d);
    n = 0;
    @(negedge clk); n++;
    div_wr = 1'b1; div_data = 8'd1;
    @(negedge clk); n++;
    div_wr = 1'b0;
    while (!cpu_ce && n < 100) begin @(negedge clk); n++; end
    chk("R9 old period kept", n, 8);
    interval(d); chk("R9 new period", d, 4);
    interval(d); chk("R9 new period", d, 4);
  endtask

  initial begin
    t_reset();
    startup_from(3'd0, SHORT, "R2 RC", 1'b0);
    startup_from(3'd4, SHORT, "R2 external", 1'b0);
    startup_from(3'd6, SHORT, "R2 code 6", 1'b1);
    startup_from(3'd1, LONG,  "R3 xtal low", 1'b0);
    startup_from(3'd2, LONG,  "R3 xtal mid", 1'b1);
    startup_from(3'd3, LONG,  "R3 xtal high", 1'b0);
    settle_ratio(0, 0, 1, "R6");
    settle_ratio(0, 1, 2, "R7");
    settle_ratio(1, 0, 4, "R8 N=1");
    settle_ratio(5, 0, 12, "R8 N=5");
    settle_ratio(3, 1, 16, "R8 N=3 halved");
    settle_ratio(255, 0, 512, "R8 N=255");
    t_glitchfree();
    startup_from(3'd0, SHORT, "R5 restart after power-down", 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule